// File: doc/BRIEF.md
# Flash Page Program Collector

This block sits behind the serial front end of a paged flash device. When a page-program command is recognised, the front end pulses a start strobe with the 24-bit target address. After that it hands over each complete data byte with a valid strobe. The block gathers these bytes into a one-page buffer. It begins at the column given by the low address bits and wraps around inside the same page. A per-column mask records which bytes arrived.

The front end also reports how the select line was released. A release on a byte boundary ends the command cleanly. Any other release abandons it. On a clean ending, if at least one byte was received and the protection logic grants the write, the block runs a self-timed program cycle. It holds a busy flag for a fixed number of clocks. During the first page-length clocks of that cycle it walks the columns in ascending order and issues one array write for each masked column. Each write is the old array byte ANDed with the buffered byte, so programming can only clear bits. The array is read through an asynchronous read port addressed by the block. `PROG_CYCLES` must be at least `PAGE_BYTES`.

Top module: `pgm_page_buffer`

## Requirements
- R1: After reset `busy` and `arr_wr_en` are 0, and no array write occurs while `busy` is 0.
- R2: The first data byte after `cmd_start` is programmed at the page selected by `cmd_addr[23:7]` and the column `cmd_addr[6:0]`. Each further byte goes to the next column.
- R3: A byte that follows column 127 goes to column 0 of the same page.
- R4: When more than 128 bytes are sent, a later byte for a column replaces the earlier one, so the last 128 bytes are programmed.
- R5: Columns that received no byte get no write strobe, and their array contents are unchanged.
- R6: `end_bad` while collecting abandons the command: `busy` stays 0 and no write occurs.
- R7: `end_ok` with no data byte received starts no program cycle.
- R8: `busy` rises in the cycle after the clock edge that samples `end_ok` and stays high for exactly `PROG_CYCLES` clock cycles.
- R9: Each write carries `arr_rd_data & buffered_byte` for its address, so bits only go from 1 to 0.
- R10: If `wr_allow` is 0 in the cycle of `end_ok`, the command is discarded with no busy and no writes.
- R11: `cmd_start`, `byte_valid` and `end_ok` are ignored while `busy` is 1. They start no new collection and no second cycle, and they change no array data.
- R12: Writes come one per clock in ascending column order, within the first 128 cycles of the busy window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_start | input | 1 | Pulse: a page-program command begins |
| cmd_addr | input | 24 | Target byte address, sampled with `cmd_start` |
| byte_valid | input | 1 | Pulse: `byte_data` holds a complete data byte |
| byte_data | input | 8 | Received data byte |
| end_ok | input | 1 | Pulse: deselect arrived on a byte boundary |
| end_bad | input | 1 | Pulse: deselect arrived mid-byte |
| wr_allow | input | 1 | Protection logic permits programming this page |
| busy | output | 1 | Self-timed program cycle in progress |
| arr_wr_en | output | 1 | Array write strobe |
| arr_wr_addr | output | 24 | Array write address |
| arr_wr_data | output | 8 | Array write data (old AND new) |
| arr_rd_addr | output | 24 | Array read address, same as the write address |
| arr_rd_data | input | 8 | Array read data, combinational from `arr_rd_addr` |

## Verification
The bench starts a burst at column 124 so that it crosses the page end. A design that did not wrap would write into the next page. It also sends 130 bytes. A design without last-wins overwrite would program the first pair of bytes instead of the final pair. The bench ends commands mid-byte, with zero bytes, and with protection withheld. A design that launched anyway would raise busy and emit writes that the scoreboard has no item for. It pokes a new start, a byte and a clean end into the middle of a busy window. A design that accepted them would either clear bits in the array or run a second cycle. The initial array bytes are not all ones, so a design that wrote the new byte without ANDing would leave set bits that the final memory comparison reports.

// File: rtl/pgb_pkg.sv
// Package: shared types for the page program collector.
// Assumes byte-wide array data.
package pgb_pkg;
    typedef logic [7:0] byte_t;
endpackage

// File: rtl/pgb_collect.sv
// Module: pgb_collect
// Gathers data bytes of one program command into a page buffer with a
// per-column valid mask. Starts at the low address bits and wraps in page.
// Assumes start requests are already gated off while a cycle is running.
module pgb_collect
    import pgb_pkg::*;
#(
    parameter int PAGE_BYTES = 128,
    parameter int ADDR_W     = 24
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    start_ok,
    input  logic [ADDR_W-1:0]                       addr,
    input  logic                                    byte_valid,
    input  byte_t                                   byte_data,
    input  logic                                    end_ok,
    input  logic                                    end_bad,
    input  logic                                    allow,
    input  logic [$clog2(PAGE_BYTES)-1:0]           rd_col,
    output logic                                    active,
    output logic                                    launch,
    output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0]    page_base,
    output byte_t                                   rd_byte,
    output logic                                    rd_valid
);
    localparam int COL_W  = $clog2(PAGE_BYTES);
    localparam int PAGE_W = ADDR_W - COL_W;

    logic                  active_q;
    logic                  got_q;
    logic [COL_W-1:0]      col_q;
    logic [PAGE_W-1:0]     page_q;
    logic [PAGE_BYTES-1:0] mask_q;
    byte_t                 buf_q [PAGE_BYTES];
    logic                  ending;
    logic                  take;

    assign ending = active_q && (end_ok || end_bad);
    assign take   = active_q && !ending && byte_valid && !start_ok;

    // Collection control: column pointer, page, mask and byte-seen flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            got_q    <= 1'b0;
            col_q    <= '0;
            page_q   <= '0;
            mask_q   <= '0;
        end else if (start_ok) begin
            active_q <= 1'b1;
            got_q    <= 1'b0;
            col_q    <= addr[COL_W-1:0];
            page_q   <= addr[ADDR_W-1:COL_W];
            mask_q   <= '0;
        end else if (ending) begin
            active_q <= 1'b0;
        end else if (take) begin
            mask_q[col_q] <= 1'b1;
            col_q         <= col_q + 1'b1;
            got_q         <= 1'b1;
        end
    end

    // Buffer storage: a later byte for a column overwrites the earlier one.
    always_ff @(posedge clk) begin
        if (take) buf_q[col_q] <= byte_data;
    end

    assign active    = active_q;
    assign launch    = active_q && end_ok && got_q && allow && !start_ok;
    assign page_base = page_q;
    assign rd_byte   = buf_q[rd_col];
    assign rd_valid  = mask_q[rd_col];

    p_col_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (take && col_q == COL_W'(PAGE_BYTES - 1)) |=> (col_q == '0));

    p_mask_mark_r5: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> mask_q[$past(col_q)]);

    p_end_stops_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ending && !start_ok) |=> !active_q);
endmodule

// File: rtl/pgb_commit.sv
// Module: pgb_commit
// Self-timed program cycle: holds busy for PROG_CYCLES clocks and scans
// the page columns in ascending order during the first PAGE_BYTES clocks.
// Assumes PROG_CYCLES >= PAGE_BYTES.
module pgb_commit #(
    parameter int PAGE_BYTES  = 128,
    parameter int PROG_CYCLES = 160
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          launch,
    output logic                          busy,
    output logic [$clog2(PAGE_BYTES)-1:0] scan_col,
    output logic                          scan_live
);
    localparam int COL_W = $clog2(PAGE_BYTES);
    localparam int CNT_W = $clog2(PROG_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PROG_CYCLES - 1);

    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;

    // Cycle timer: starts on launch, drops busy after the last count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (!busy_q) begin
            busy_q <= launch;
            cnt_q  <= '0;
        end else if (cnt_q == LAST) begin
            busy_q <= 1'b0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign busy      = busy_q;
    assign scan_col  = cnt_q[COL_W-1:0];
    assign scan_live = busy_q && (cnt_q < CNT_W'(PAGE_BYTES));

    p_busy_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> ($past(cnt_q) == LAST));

    p_busy_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_q) |-> (cnt_q == '0));
endmodule

// File: rtl/pgm_page_buffer.sv
// Module: pgm_page_buffer (top)
// Page-program data collector and committer. Bytes are collected into a
// one-page buffer, then ANDed into the array during a self-timed cycle.
// Assumes the array read port is combinational from arr_rd_addr.
module pgm_page_buffer
    import pgb_pkg::*;
#(
    parameter int PAGE_BYTES  = 128,
    parameter int ADDR_W      = 24,
    parameter int PROG_CYCLES = 160
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              byte_valid,
    input  logic [7:0]        byte_data,
    input  logic              end_ok,
    input  logic              end_bad,
    input  logic              wr_allow,
    output logic              busy,
    output logic              arr_wr_en,
    output logic [ADDR_W-1:0] arr_wr_addr,
    output logic [7:0]        arr_wr_data,
    output logic [ADDR_W-1:0] arr_rd_addr,
    input  logic [7:0]        arr_rd_data
);
    localparam int COL_W  = $clog2(PAGE_BYTES);
    localparam int PAGE_W = ADDR_W - COL_W;

    logic              start_ok;
    logic              active;
    logic              launch;
    logic [PAGE_W-1:0] page_base;
    byte_t             rd_byte;
    logic              rd_valid;
    logic [COL_W-1:0]  scan_col;
    logic              scan_live;

    assign start_ok = cmd_start && !busy;

    pgb_collect #(.PAGE_BYTES(PAGE_BYTES), .ADDR_W(ADDR_W)) u_collect (
        .clk(clk), .rst_n(rst_n), .start_ok(start_ok), .addr(cmd_addr),
        .byte_valid(byte_valid && !busy), .byte_data(byte_data),
        .end_ok(end_ok && !busy), .end_bad(end_bad && !busy), .allow(wr_allow),
        .rd_col(scan_col), .active(active), .launch(launch),
        .page_base(page_base), .rd_byte(rd_byte), .rd_valid(rd_valid)
    );

    pgb_commit #(.PAGE_BYTES(PAGE_BYTES), .PROG_CYCLES(PROG_CYCLES)) u_commit (
        .clk(clk), .rst_n(rst_n), .launch(launch), .busy(busy),
        .scan_col(scan_col), .scan_live(scan_live)
    );

    // Array port: one AND-merge write per masked column during the scan.
    always_comb begin
        arr_rd_addr = {page_base, scan_col};
        arr_wr_addr = {page_base, scan_col};
        arr_wr_en   = scan_live && rd_valid;
        arr_wr_data = arr_rd_data & rd_byte;
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !arr_wr_en);

    p_only_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        arr_wr_en |-> ((arr_wr_data & ~arr_rd_data) == 8'h00));

    p_no_collect_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !active);

    p_launch_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> !busy);
endmodule

// File: tb/pgm_page_buffer_bench.sv
`timescale 1ns/1ps
module pgm_page_buffer_bench;
    localparam int PAGE = 128;
    localparam int PROG = 160;
    localparam int MEMN = 512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_start = 1'b0;
    logic [23:0] cmd_addr = '0;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_data = '0;
    logic        end_ok = 1'b0;
    logic        end_bad = 1'b0;
    logic        wr_allow = 1'b1;
    logic        busy;
    logic        arr_wr_en;
    logic [23:0] arr_wr_addr;
    logic [7:0]  arr_wr_data;
    logic [23:0] arr_rd_addr;
    logic [7:0]  arr_rd_data;

    int    checks = 0;
    int    errors = 0;
    string ctx = "R1";
    logic [7:0]  mem [MEMN];
    logic [7:0]  exp_mem [MEMN];
    logic [31:0] exp_q [$];

    always #4 clk = ~clk;

    pgm_page_buffer u_pgm_page_buffer (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_addr(cmd_addr),
        .byte_valid(byte_valid), .byte_data(byte_data), .end_ok(end_ok),
        .end_bad(end_bad), .wr_allow(wr_allow), .busy(busy),
        .arr_wr_en(arr_wr_en), .arr_wr_addr(arr_wr_addr),
        .arr_wr_data(arr_wr_data), .arr_rd_addr(arr_rd_addr),
        .arr_rd_data(arr_rd_data)
    );

    assign arr_rd_data = mem[arr_rd_addr[8:0]];

    always @(posedge clk) begin
        if (arr_wr_en) mem[arr_wr_addr[8:0]] <= arr_wr_data;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: every array write must match the next scoreboard item (R2 R12).
    always @(negedge clk) begin
        if (rst_n && arr_wr_en) begin
            if (exp_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL %s unexpected write actual %h expected none", ctx, {arr_wr_addr, arr_wr_data});
            end else begin
                logic [31:0] item;
                item = exp_q.pop_front();
                check({arr_wr_addr, arr_wr_data} === item, ctx, {arr_wr_addr, arr_wr_data}, item);
            end
        end
    end

    // Driver: sends one command and pushes the expected writes.
    task automatic run(input string req, input int addr, input int n, input int seed,
                       input bit bad, input bit allow, input bit poke);
        bit         hit [PAGE];
        logic [7:0] nv [PAGE];
        bit         go;
        int         cnt;
        int         miss;
        ctx = req;
        for (int c = 0; c < PAGE; c++) hit[c] = 1'b0;
        @(negedge clk);
        cmd_start = 1'b1;
        cmd_addr  = addr[23:0];
        @(negedge clk);
        cmd_start = 1'b0;
        for (int k = 0; k < n; k++) begin
            logic [7:0] d;
            int col;
            d = 8'((seed * 13) + (k * 29) + 7);
            col = (addr + k) % PAGE;
            nv[col] = d;
            hit[col] = 1'b1;
            byte_valid = 1'b1;
            byte_data  = d;
            @(negedge clk);
        end
        byte_valid = 1'b0;
        go = !bad && (n > 0) && allow;
        if (go) begin
            for (int c = 0; c < PAGE; c++) begin
                if (hit[c]) begin
                    int a;
                    logic [7:0] v;
                    a = (addr / PAGE) * PAGE + c;
                    v = exp_mem[a] & nv[c];
                    exp_mem[a] = v;
                    exp_q.push_back({a[23:0], v});
                end
            end
        end
        wr_allow = allow;
        if (bad) end_bad = 1'b1;
        else     end_ok  = 1'b1;
        @(negedge clk);
        end_ok   = 1'b0;
        end_bad  = 1'b0;
        wr_allow = 1'b1;
        check(busy == go, {req, " busy after end R8"}, int'(busy), int'(go));
        cnt = 0;
        while (busy && cnt < PROG + 10) begin
            cnt++;
            if (poke && cnt == 5) begin cmd_start = 1'b1; cmd_addr = addr[23:0] + 24'd3; end
            if (poke && cnt == 6) begin cmd_start = 1'b0; byte_valid = 1'b1; byte_data = 8'h00; end
            if (poke && cnt == 7) begin byte_valid = 1'b0; end_ok = 1'b1; end
            if (poke && cnt == 8) end_ok = 1'b0;
            @(negedge clk);
        end
        if (go) check(cnt == PROG, {req, " busy length R8"}, cnt, PROG);
        else begin
            repeat (PROG + 4) begin
                @(negedge clk);
                if (busy) cnt++;
            end
            check(cnt == 0, {req, " stays idle"}, cnt, 0);
        end
        repeat (4) @(negedge clk);
        check(busy == 1'b0, {req, " no relaunch R11"}, int'(busy), 0);
        check(exp_q.size() == 0, {req, " all writes seen R12"}, exp_q.size(), 0);
        miss = 0;
        for (int i = 0; i < MEMN; i++) if (mem[i] !== exp_mem[i]) miss++;
        check(miss == 0, {req, " array contents R5 R9"}, miss, 0);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL R8 watchdog actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < MEMN; i++) begin
            mem[i]     = 8'((i * 37) + 5) | 8'h81;
            exp_mem[i] = 8'((i * 37) + 5) | 8'h81;
        end
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R1 busy in reset", int'(busy), 0);
        check(arr_wr_en == 1'b0, "R1 write strobe in reset", int'(arr_wr_en), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
        run("R2 R9 start column", 24'h000010, 5, 1, 1'b0, 1'b1, 1'b0);
        run("R3 page wrap", 24'h0000FC, 10, 2, 1'b0, 1'b1, 1'b0);
        run("R4 last bytes win", 24'h000105, 130, 3, 1'b0, 1'b1, 1'b0);
        run("R6 misaligned end", 24'h000180, 3, 4, 1'b1, 1'b1, 1'b0);
        run("R7 no data", 24'h000040, 0, 5, 1'b0, 1'b1, 1'b0);
        run("R10 protected", 24'h000020, 4, 6, 1'b0, 1'b0, 1'b0);
        run("R11 start while busy", 24'h0001A0, 3, 7, 1'b0, 1'b1, 1'b1);
        run("R5 R12 same column reprogram", 24'h000012, 2, 9, 1'b0, 1'b1, 1'b0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule